// File: doc/BRIEF.md
# Single-Wire Debug Bit Receiver

This block listens to the host side of an open-drain, single-wire debug line and turns each host pulse into a decoded event. The line idles high. Every bit starts with a falling edge. The receiver counts how many debug-clock ticks the line stays low, with the ticks given by a clock-enable input, and decides what the pulse meant once the line is released. A short low is a logic 1, a longer low is a logic 0, and a very long low on the first bit of a command is a resynchronisation request. Pulses that fit none of these are reported as errors.

The receiver keeps track of whether the next pulse opens a new command. It flags the first decoded bit of a command so that a downstream framer can group the bits. Once a command has started, each new bit must begin within a fixed window of ticks after the previous one. If no bit arrives in time, a timeout strobe is raised and the receiver goes back to waiting for a first bit. Every result is a one-cycle strobe.

Top module: `dbg_bit_rx`

## Requirements
- R1: During and straight after reset, all of `bit_valid`, `first_bit`, `sync_req`, `timeout` and `pulse_err` are low, and the next pulse is treated as the first bit of a command.
- R2: A low time of ONE_LOW_MIN to SAMPLE_TICK-1 ticks (4 to 9 by default) gives `bit_valid` with `bit_value`=1 when the line is released.
- R3: A low time of ZERO_LOW_MIN (12) ticks or more gives `bit_valid` with `bit_value`=0. On a bit that is not first, the low time must also be at most BIT_WINDOW-1 ticks. On a first bit, it must also be below SYNC_LOW_MIN ticks.
- R4: On a first bit, a low time of SYNC_LOW_MIN ticks or more raises `sync_req` when the line is released and emits no bit. The following pulse is still a first bit.
- R5: A low time below ONE_LOW_MIN ticks, or of SAMPLE_TICK to ZERO_LOW_MIN-1 ticks (10 and 11), raises `pulse_err` and emits no bit. The following pulse is then a first bit.
- R6: On a bit that is not first, if the line is still low BIT_WINDOW ticks after its falling edge, `pulse_err` is raised at once without waiting for release. The following pulse is then a first bit.
- R7: Within a command, a falling edge that comes BIT_WINDOW ticks or fewer after the previous falling edge is accepted. If none has come by then, `timeout` is raised and the next pulse is a first bit.
- R8: `first_bit` is high together with `bit_valid` exactly when the decoded bit is the first of a command.
- R9: Every duration is counted in cycles with `tick_en` high. Cycles with `tick_en` low do not advance any timing.
- R10: At most one of `bit_valid`, `sync_req`, `timeout` and `pulse_err` is high in any cycle, and each is high for a single cycle per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Debug-clock tick; timing advances only on cycles where it is high |
| line_in | input | 1 | Raw debug line level, asynchronous, idles high |
| bit_valid | output | 1 | One-cycle strobe: a data bit was decoded |
| bit_value | output | 1 | Value of the decoded bit, qualified by `bit_valid` |
| first_bit | output | 1 | With `bit_valid`: this bit opens a command |
| sync_req | output | 1 | One-cycle strobe: resynchronisation request seen |
| timeout | output | 1 | One-cycle strobe: inter-bit window expired |
| pulse_err | output | 1 | One-cycle strobe: malformed or overlong pulse |

## Verification
The bench builds the receiver with BIT_WINDOW=64 and SYNC_LOW_MIN=24 and keeps the 4/10/12 bit thresholds. With a window this short, it can sweep every low time from 1 to 68 ticks, both as a first bit and as a later bit, and compare each result with a class computed from the thresholds. It also places the next falling edge exactly on the window limit and one tick past it. A pass with `tick_en` toggling on alternate cycles shows that cycles without a tick do not count, because the same pulse lengths in clock cycles would decode differently if they did.

// File: rtl/dbg_bit_rx_pkg.sv
`timescale 1ns/1ps
package dbg_bit_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,   // line high, waiting for a falling edge
    ST_LOW,    // measuring the low phase of a bit
    ST_DRAIN   // overlong low reported, waiting for release
  } rx_state_e;

  typedef enum logic [1:0] {
    EV_ONE,
    EV_ZERO,
    EV_SYNC,
    EV_ERR
  } rx_event_e;

  // Class of a pulse, judged from its low length at the moment of release.
  function automatic rx_event_e judge_release(
    input int unsigned low_ticks,
    input logic        first,
    input int unsigned one_min,
    input int unsigned sample_at,
    input int unsigned zero_min,
    input int unsigned sync_min,
    input int unsigned window
  );
    if (low_ticks < one_min)               return EV_ERR;
    if (low_ticks < sample_at)             return EV_ONE;
    if (low_ticks < zero_min)              return EV_ERR;
    if (first && low_ticks >= sync_min)    return EV_SYNC;
    if (low_ticks < window)                return EV_ZERO;
    return EV_ERR;
  endfunction

endpackage

// File: rtl/dbg_line_sync.sv
`timescale 1ns/1ps
module dbg_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic line_in,
  output logic fell,
  output logic rose
);
  logic meta_q, sync_q, prev_q;

  // Two-flop synchroniser on every clock; line idles high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= line_in;
      sync_q <= meta_q;
    end
  end

  // Previous sample only advances on debug ticks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= 1'b1;
    else if (tick_en) prev_q <= sync_q;
  end

  assign fell = tick_en &  prev_q & ~sync_q;
  assign rose = tick_en & ~prev_q &  sync_q;

endmodule

// File: rtl/dbg_tick_counter.sv
`timescale 1ns/1ps
module dbg_tick_counter #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             restart,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] SAT = '1;

  // Ticks since the last falling edge, counting that edge's tick as 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (tick_en) begin
      if (restart)                   count <= WIDTH'(1);
      else if (count != SAT)         count <= count + WIDTH'(1);
    end
  end

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count)); // R9

endmodule

// File: rtl/dbg_bit_rx.sv
`timescale 1ns/1ps
module dbg_bit_rx
  import dbg_bit_rx_pkg::*;
#(
  parameter int unsigned ONE_LOW_MIN  = 4,
  parameter int unsigned SAMPLE_TICK  = 10,
  parameter int unsigned ZERO_LOW_MIN = 12,
  parameter int unsigned SYNC_LOW_MIN = 128,
  parameter int unsigned BIT_WINDOW   = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic line_in,
  output logic bit_valid,
  output logic bit_value,
  output logic first_bit,
  output logic sync_req,
  output logic timeout,
  output logic pulse_err
);
  localparam int unsigned      CNT_W   = $clog2(BIT_WINDOW + 1);
  localparam logic [CNT_W-1:0] WIN_CNT = CNT_W'(BIT_WINDOW);

  logic             fell_tick, rise_tick;
  logic [CNT_W-1:0] low_ticks;
  rx_state_e        state;
  logic             first_pend;
  rx_event_e        release_ev;
  logic             window_hit;

  dbg_line_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .line_in (line_in),
    .fell    (fell_tick),
    .rose    (rise_tick)
  );

  dbg_tick_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .restart (fell_tick),
    .count   (low_ticks)
  );

  assign release_ev = judge_release(32'(low_ticks), first_pend, ONE_LOW_MIN,
                                    SAMPLE_TICK, ZERO_LOW_MIN, SYNC_LOW_MIN,
                                    BIT_WINDOW);
  assign window_hit = (low_ticks == WIN_CNT) && !first_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      first_pend <= 1'b1;
      bit_valid  <= 1'b0;
      bit_value  <= 1'b0;
      first_bit  <= 1'b0;
      sync_req   <= 1'b0;
      timeout    <= 1'b0;
      pulse_err  <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      first_bit <= 1'b0;
      sync_req  <= 1'b0;
      timeout   <= 1'b0;
      pulse_err <= 1'b0;
      if (tick_en) begin
        unique case (state)
          ST_IDLE: begin
            if (fell_tick) begin
              state <= ST_LOW;
            end else if (window_hit) begin
              timeout    <= 1'b1;
              first_pend <= 1'b1;
            end
          end
          ST_LOW: begin
            if (rise_tick) begin
              state <= ST_IDLE;
              unique case (release_ev)
                EV_ONE, EV_ZERO: begin
                  bit_valid  <= 1'b1;
                  bit_value  <= (release_ev == EV_ONE);
                  first_bit  <= first_pend;
                  first_pend <= 1'b0;
                end
                EV_SYNC: sync_req <= 1'b1;
                default: begin
                  pulse_err  <= 1'b1;
                  first_pend <= 1'b1;
                end
              endcase
            end else if (window_hit) begin
              pulse_err  <= 1'b1;
              first_pend <= 1'b1;
              state      <= ST_DRAIN;
            end
          end
          default: begin
            if (rise_tick) state <= ST_IDLE;
          end
        endcase
      end
    end
  end

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_valid, sync_req, timeout, pulse_err})); // R10
  AST_FIRST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    first_bit |-> bit_valid); // R8
  AST_BIT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(rise_tick)); // R2
  AST_SYNC_KEEPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> first_pend); // R4
  AST_ERR_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err |-> first_pend); // R5
  AST_TIMEOUT_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (first_pend && state == ST_IDLE)); // R7

endmodule

// File: tb/test_dbg_bit_rx.sv
`timescale 1ns/1ps
module test_dbg_bit_rx;
  localparam int WIN     = 64;
  localparam int SYNCM   = 24;
  localparam int ONE_MIN = 4;
  localparam int SAMP    = 10;
  localparam int ZMIN    = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tick_en, line_in;
  logic bit_valid, bit_value, first_bit, sync_req, timeout, pulse_err;

  dbg_bit_rx #(
    .ONE_LOW_MIN(ONE_MIN), .SAMPLE_TICK(SAMP), .ZERO_LOW_MIN(ZMIN),
    .SYNC_LOW_MIN(SYNCM), .BIT_WINDOW(WIN)
  ) i_dbg_bit_rx (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .line_in(line_in),
    .bit_valid(bit_valid), .bit_value(bit_value), .first_bit(first_bit),
    .sync_req(sync_req), .timeout(timeout), .pulse_err(pulse_err)
  );

  int n_tests = 0, n_fail = 0;
  int n_bit, n_sync, n_to, n_err, n_multi, last_val, last_first;
  bit div_mode = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(bit_valid) + int'(sync_req) + int'(timeout) + int'(pulse_err) > 1)
        n_multi++;
      if (bit_valid) begin n_bit++; last_val = bit_value; last_first = first_bit; end
      if (sync_req)  n_sync++;
      if (timeout)   n_to++;
      if (pulse_err) n_err++;
    end
  end

  task automatic clear_counts();
    n_bit = 0; n_sync = 0; n_to = 0; n_err = 0; last_val = -1; last_first = -1;
  endtask

  task automatic check(string req, string what, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // One enabled tick per call.
  task automatic step();
    if (!div_mode) begin
      @(posedge clk); #1;
    end else begin
      @(posedge clk); #1 tick_en = 1'b0;
      @(posedge clk); #1 tick_en = 1'b1;
    end
  endtask

  task automatic pulse(int low, int high);
    line_in = 1'b0;
    repeat (low) step();
    line_in = 1'b1;
    repeat (high) step();
  endtask

  task automatic idle();
    line_in = 1'b1;
    repeat (WIN + 10) step();
  endtask

  // 0: one, 1: zero, 2: sync, 3: error
  function automatic int exp_kind(int low, bit first);
    if (low >= ONE_MIN && low <= SAMP - 1) return 0;
    if (first) begin
      if (low >= SYNCM) return 2;
      return (low >= ZMIN) ? 1 : 3;
    end
    return (low >= ZMIN && low < WIN) ? 1 : 3;
  endfunction

  task automatic judge(int low, bit first);
    int k;
    int code;
    string tag;
    k = exp_kind(low, first);
    code = (k < 2) ? 100 : (k == 2) ? 10 : 1;
    tag = (k == 0) ? "R2" : (k == 1) ? "R3" : (k == 2) ? "R4" : (low >= WIN) ? "R6" : "R5";
    check(tag, $sformatf("event code low=%0d first=%0d", low, first),
          n_bit * 100 + n_sync * 10 + n_err, code);
    if (k < 2) begin
      check(tag, $sformatf("bit value low=%0d", low), last_val, (k == 0) ? 1 : 0);
      check("R8", $sformatf("first flag low=%0d", low), last_first, int'(first));
    end
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; line_in = 1'b1;
    n_multi = 0; clear_counts();
    repeat (4) @(posedge clk);
    #1;
    check("R1", "strobes in reset",
          int'({bit_valid, first_bit, sync_req, timeout, pulse_err}), 0);
    rst_n = 1'b1;
    repeat (3) step();
    check("R1", "strobes after reset",
          int'({bit_valid, first_bit, sync_req, timeout, pulse_err}), 0);
    clear_counts();
    pulse(5, 8);
    check("R1", "first pulse after reset is first", last_first, 1);

    // Sweep every low length, as first bit and as later bit.
    for (int len = 1; len <= WIN + 4; len++) begin
      idle(); clear_counts();
      pulse(len, 8);
      judge(len, 1'b1);
      idle();
      pulse(5, 12); clear_counts();
      pulse(len, 8);
      judge(len, 1'b0);
    end

    // R7: next fall exactly at the window limit, then one tick late.
    idle(); clear_counts();
    pulse(5, WIN - 5); pulse(5, 8);
    check("R7", "timeouts at limit", n_to, 0);
    check("R7", "bits at limit", n_bit, 2);
    check("R7", "second bit continues command", last_first, 0);
    idle(); clear_counts();
    pulse(5, WIN + 1 - 5); pulse(5, 8);
    check("R7", "timeouts past limit", n_to, 1);
    check("R7", "late bit opens command", last_first, 1);

    // R4: sync leaves receiver expecting a first bit.
    idle(); clear_counts();
    pulse(SYNCM + 6, 8); pulse(5, 8);
    check("R4", "sync count", n_sync, 1);
    check("R4", "bit after sync is first", last_first, 1);

    // R5: error mid-command rearms.
    idle(); pulse(5, 8); clear_counts();
    pulse(2, 8); pulse(5, 8);
    check("R5", "short pulse error", n_err, 1);
    check("R5", "bit after error is first", last_first, 1);

    // R6: overlong low reported before release.
    idle(); pulse(5, 12); clear_counts();
    line_in = 1'b0;
    repeat (WIN + 6) step();
    check("R6", "error while still low", n_err, 1);
    check("R6", "no bit while still low", n_bit, 0);
    line_in = 1'b1;
    repeat (8) step();
    check("R6", "no extra event on release", n_bit + n_err + n_sync, 1);

    // R9: ticks on alternate cycles.
    div_mode = 1'b1;
    idle(); clear_counts();
    pulse(8, 8);
    check("R9", "8 ticks over 16 clocks decodes 1", n_bit * 10 + last_val, 11);
    idle(); clear_counts();
    pulse(14, 8);
    check("R9", "14 ticks over 28 clocks decodes 0", n_bit * 10 + last_val, 10);
    div_mode = 1'b0;
    tick_en = 1'b1;

    check("R10", "cycles with several strobes", n_multi, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule